// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Index/Data Configuration Port

This block is a watchdog timer whose settings sit behind a two-port index/data byte interface. Software writes a register number to the index port, then reads or writes that register through the data port. The configuration space stays closed until a two-byte unlock key arrives on the index port. Even after unlocking, only the page-number register is reachable until the watchdog page has been selected. A single relock key on the index port closes the space again.

The watchdog page holds four registers:

- **0x30** carries the enable bit.
- **0xF5** carries the seconds/minutes unit bit.
- **0xF6** is the 8-bit live counter.
- **0xF7** carries the keyboard and mouse reload-source bits.

The counter steps down once per unit. A unit is one pulse of the `tick` input in seconds mode, or `TICKS_PER_MIN` pulses in minutes mode. When the count reaches zero while the watchdog is enabled, the block raises `rst_req` and holds it.

Activity on the keyboard or mouse interrupt inputs can restart the count from the last loaded timeout, if the matching source bit is set. Out of reset, the block is set up for a five-unit timeout in minutes, with the watchdog disabled.

Top module: `wdt_cfgport`

## Requirements
- R1: After reset the space is locked (data reads give 0xFF), `rst_req` is 0, and once opened the page reads 0x30=0x00, 0xF5=0x08, 0xF6=0x05 (`DEF_COUNT`), 0xF7=0x00.
- R2: Two consecutive index writes of 0x87 unlock the space; any other index write between them restarts key matching, and reads stay 0xFF.
- R3: While unlocked, writing 0x08 to register 0x07 selects the watchdog page; until then page registers read 0x00 and writes to them are ignored.
- R4: An index write of 0xAA relocks the space and deselects the page; afterwards data writes are ignored and data reads return 0xFF.
- R5: Bit 0 of register 0x30 enables the watchdog (1 = on); all eight bits of 0x30 read back as written.
- R6: Bit 3 of register 0xF5 picks the unit (0 = every `tick` pulse, 1 = every `TICKS_PER_MIN` pulses); all bits read back as written.
- R7: A write to register 0xF6 loads the counter and the reload value, restarts the unit prescaler, and clears `rst_req`; reading 0xF6 returns the live count.
- R8: While enabled, the count drops by one per unit; when it steps from 1 to 0, `rst_req` rises in that cycle and holds while the count sits at zero.
- R9: Loading 0 while enabled starts no countdown and raises no `rst_req`.
- R10: While enabled, a `kbd_irq` pulse with 0xF7 bit 6 set, or a `mouse_irq` pulse with 0xF7 bit 7 set, reloads the counter with the last value written to 0xF6; with the bit clear the pulse has no effect.
- R11: Any other address on the watchdog page reads 0x00.
- R12: While disabled, the count holds and `rst_req` is low from the cycle after the enable bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| wdata | input | 8 | Write byte for either port |
| rdata | output | 8 | Data-port read value for the current index |
| tick | input | 1 | One-cycle base time pulse (one second) |
| kbd_irq | input | 1 | Keyboard activity pulse |
| mouse_irq | input | 1 | Mouse activity pulse |
| rst_req | output | 1 | Watchdog expiry reset request |

## Verification
A lock state machine stuck in the wrong state shows up on the very next data read: it returns 0xFF where a register value is expected, or the reverse. A wrong page decode shows the same way on the next read. A miscounting prescaler or counter shows as a wrong live count on the read of 0xF6 right after the tick pulse that should have moved it. It also shows as `rst_req` rising one unit early or late. A reload source that is wired wrongly appears as an unchanged or wrongly restored count on the 0xF6 read right after the activity pulse.

// File: rtl/wdt_cfg_pkg.sv
package wdt_cfg_pkg;
   typedef enum logic [1:0] {
      LK_SHUT = 2'd0,
      LK_HALF = 2'd1,
      LK_OPEN = 2'd2
   } lock_e;

   localparam int unsigned BYTE_W = 8;

   localparam logic [7:0] KEY_OPEN = 8'h87;
   localparam logic [7:0] KEY_SHUT = 8'hAA;
   localparam logic [7:0] IX_PAGE  = 8'h07;
   localparam logic [7:0] PAGE_WD  = 8'h08;
   localparam logic [7:0] IX_ENA   = 8'h30;
   localparam logic [7:0] IX_UNIT  = 8'hF5;
   localparam logic [7:0] IX_CNT   = 8'hF6;
   localparam logic [7:0] IX_SRC   = 8'hF7;

   localparam int unsigned BIT_ENA  = 0;
   localparam int unsigned BIT_MIN  = 3;
   localparam int unsigned BIT_KBD  = 6;
   localparam int unsigned BIT_MS   = 7;
endpackage

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
   import wdt_cfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              is_open
);
   lock_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= LK_SHUT;
      end else if (idx_wr) begin
         case (st)
            LK_SHUT: st <= (wdata == KEY_OPEN) ? LK_HALF : LK_SHUT;
            LK_HALF: st <= (wdata == KEY_OPEN) ? LK_OPEN : LK_SHUT;
            default: st <= (wdata == KEY_SHUT) ? LK_SHUT : LK_OPEN;
         endcase
      end
   end

   assign is_open = (st == LK_OPEN);
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import wdt_cfg_pkg::*;
#(
   parameter bit DEF_ENABLE  = 1'b0,
   parameter bit DEF_MINUTES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_open,
   input  logic              idx_wr,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] cnt_val,
   output logic [BYTE_W-1:0] rdata,
   output logic              ena,
   output logic              minutes,
   output logic              kbd_src,
   output logic              ms_src,
   output logic              cnt_load
);
   logic [BYTE_W-1:0] index_q, page_q, ena_q, unit_q, src_q;
   logic              page_hit;

   assign page_hit = (page_q == PAGE_WD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= '0;
         page_q  <= '0;
         ena_q   <= {{(BYTE_W-1){1'b0}}, DEF_ENABLE};
         unit_q  <= DEF_MINUTES ? (BYTE_W'(1) << BIT_MIN) : '0;
         src_q   <= '0;
      end else begin
         if (idx_wr && is_open) begin
            if (wdata == KEY_SHUT) page_q <= '0;
            else                   index_q <= wdata;
         end
         if (data_wr && is_open) begin
            if (index_q == IX_PAGE) begin
               page_q <= wdata;
            end else if (page_hit) begin
               case (index_q)
                  IX_ENA:  ena_q  <= wdata;
                  IX_UNIT: unit_q <= wdata;
                  IX_SRC:  src_q  <= wdata;
                  default: ;
               endcase
            end
         end
      end
   end

   assign cnt_load = data_wr && is_open && page_hit && (index_q == IX_CNT);
   assign ena      = ena_q[BIT_ENA];
   assign minutes  = unit_q[BIT_MIN];
   assign kbd_src  = src_q[BIT_KBD];
   assign ms_src   = src_q[BIT_MS];

   always_comb begin
      rdata = '0;
      if (!is_open) begin
         rdata = '1;
      end else if (index_q == IX_PAGE) begin
         rdata = page_q;
      end else if (page_hit) begin
         case (index_q)
            IX_ENA:  rdata = ena_q;
            IX_UNIT: rdata = unit_q;
            IX_CNT:  rdata = cnt_val;
            IX_SRC:  rdata = src_q;
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int unsigned CW            = 8,
   parameter int unsigned TICKS_PER_MIN = 60,
   parameter int unsigned DEF_COUNT     = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ena,
   input  logic          minutes,
   input  logic          load,
   input  logic [CW-1:0] ld_val,
   input  logic          kbd_src,
   input  logic          ms_src,
   input  logic          kbd_irq,
   input  logic          ms_irq,
   input  logic          tick,
   output logic [CW-1:0] cnt,
   output logic          step,
   output logic          expired
);
   localparam int unsigned PW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;

   logic          act;
   logic [CW-1:0] rl_q;

   assign act = ena && ((kbd_src && kbd_irq) || (ms_src && ms_irq));

   generate
      if (TICKS_PER_MIN > 1) begin : g_pre
         logic [PW-1:0] pre_q;
         logic          pre_end;
         assign pre_end = (pre_q == PW'(TICKS_PER_MIN - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)                      pre_q <= '0;
            else if (load || act)            pre_q <= '0;
            else if (ena && minutes && tick) pre_q <= pre_end ? '0 : pre_q + 1'b1;
         end
         assign step = tick && (!minutes || pre_end);
      end else begin : g_nopre
         assign step = tick;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= CW'(DEF_COUNT);
         rl_q    <= CW'(DEF_COUNT);
         expired <= 1'b0;
      end else if (load) begin
         cnt     <= ld_val;
         rl_q    <= ld_val;
         expired <= 1'b0;
      end else if (!ena) begin
         expired <= 1'b0;
      end else if (act) begin
         cnt     <= rl_q;
         expired <= 1'b0;
      end else if (step && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
         if (cnt == CW'(1)) expired <= 1'b1;
      end
   end
endmodule

// File: rtl/wdt_cfgport.sv
module wdt_cfgport
   import wdt_cfg_pkg::*;
#(
   parameter int unsigned TICKS_PER_MIN = 60,
   parameter int unsigned DEF_COUNT     = 5,
   parameter bit          DEF_MINUTES   = 1'b1,
   parameter bit          DEF_ENABLE    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       tick,
   input  logic       kbd_irq,
   input  logic       mouse_irq,
   output logic       rst_req
);
   localparam int unsigned CW = BYTE_W;

   generate
      if (TICKS_PER_MIN < 1 || TICKS_PER_MIN > 65535) begin : g_bad_tpm
         $error("TICKS_PER_MIN out of range");
      end
      if (DEF_COUNT >= (1 << CW)) begin : g_bad_def
         $error("DEF_COUNT does not fit the counter");
      end
   endgenerate

   logic          open_w, ena_w, min_w, kbd_src_w, ms_src_w, load_w, step_w;
   logic [CW-1:0] cnt_w;

   wdt_key_fsm u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (idx_wr),
      .wdata   (wdata),
      .is_open (open_w)
   );

   wdt_regfile #(
      .DEF_ENABLE  (DEF_ENABLE),
      .DEF_MINUTES (DEF_MINUTES)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_open  (open_w),
      .idx_wr   (idx_wr),
      .data_wr  (data_wr),
      .wdata    (wdata),
      .cnt_val  (cnt_w),
      .rdata    (rdata),
      .ena      (ena_w),
      .minutes  (min_w),
      .kbd_src  (kbd_src_w),
      .ms_src   (ms_src_w),
      .cnt_load (load_w)
   );

   wdt_countdown #(
      .CW            (CW),
      .TICKS_PER_MIN (TICKS_PER_MIN),
      .DEF_COUNT     (DEF_COUNT)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ena     (ena_w),
      .minutes (min_w),
      .load    (load_w),
      .ld_val  (wdata),
      .kbd_src (kbd_src_w),
      .ms_src  (ms_src_w),
      .kbd_irq (kbd_irq),
      .ms_irq  (mouse_irq),
      .tick    (tick),
      .cnt     (cnt_w),
      .step    (step_w),
      .expired (rst_req)
   );
endmodule

// File: rtl/wdt_cfgport_chk.sv
module wdt_cfgport_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       idx_wr,
   input logic       data_wr,
   input logic [7:0] wdata,
   input logic [7:0] rdata,
   input logic       ena,
   input logic       kbd_src,
   input logic       ms_src,
   input logic       kbd_irq,
   input logic       ms_irq,
   input logic       load,
   input logic       step,
   input logic [7:0] cnt,
   input logic       rst_req
);
   logic act;
   assign act = ena && ((kbd_src && kbd_irq) || (ms_src && ms_irq));

   // R4
   relock_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr && !data_wr && wdata == 8'hAA) |=> (rdata == 8'hFF));

   // R8
   step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ena && step && cnt != 8'd0 && !load && !act) |=> (cnt == $past(cnt) - 8'd1));

   // R8
   expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == 8'd0));

   // R9
   zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && wdata == 8'd0) |=> (!rst_req && cnt == 8'd0));

   // R12
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ena && !$past(ena)) |-> !rst_req);

   // R12
   off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ena && !load) |=> $stable(cnt));

   // R10
   act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !load) |=> !rst_req);
endmodule

bind wdt_cfgport wdt_cfgport_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .idx_wr  (idx_wr),
   .data_wr (data_wr),
   .wdata   (wdata),
   .rdata   (rdata),
   .ena     (ena_w),
   .kbd_src (kbd_src_w),
   .ms_src  (ms_src_w),
   .kbd_irq (kbd_irq),
   .ms_irq  (mouse_irq),
   .load    (load_w),
   .step    (step_w),
   .cnt     (cnt_w),
   .rst_req (rst_req)
);

// File: tb/sim_wdt_cfgport.sv
module sim_wdt_cfgport;
   localparam int TPM = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       idx_wr = 1'b0, data_wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       tick = 1'b0, kbd_irq = 1'b0, mouse_irq = 1'b0;
   logic       rst_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   wdt_cfgport #(.TICKS_PER_MIN(TPM)) u0 (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
      .wdata(wdata), .rdata(rdata), .tick(tick), .kbd_irq(kbd_irq),
      .mouse_irq(mouse_irq), .rst_req(rst_req)
   );

   // {index, write value, expected read}
   localparam logic [23:0] VT [8] = '{
      24'h30A5A5,   // R5
      24'h300000,   // R5
      24'hF5F7F7,   // R6
      24'hF50808,   // R6
      24'hF63C3C,   // R7
      24'hF7C0C0,   // R10
      24'hF73F3F,   // R10
      24'h127700    // R11
   };
   localparam int VT_REQ [8] = '{5, 5, 6, 6, 7, 10, 10, 11};

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_idx(input logic [7:0] v);
      @(negedge clk); idx_wr = 1'b1; wdata = v;
      @(negedge clk); idx_wr = 1'b0;
   endtask

   task automatic wr_dat(input logic [7:0] v);
      @(negedge clk); data_wr = 1'b1; wdata = v;
      @(negedge clk); data_wr = 1'b0;
   endtask

   task automatic wreg(input logic [7:0] a, input logic [7:0] d);
      wr_idx(a); wr_dat(d);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      wr_idx(a); v = rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic kbd_pulse();
      @(negedge clk); kbd_irq = 1'b1;
      @(negedge clk); kbd_irq = 1'b0;
   endtask

   task automatic ms_pulse();
      @(negedge clk); mouse_irq = 1'b1;
      @(negedge clk); mouse_irq = 1'b0;
   endtask

   task automatic open_page();
      wr_idx(8'h87); wr_idx(8'h87); wreg(8'h07, 8'h08);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         summary();
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 locked read", rdata, 8'hFF);
      chk("R1 rst_req", {7'd0, rst_req}, 8'h00);

      // R2 interrupted key stays locked
      wr_idx(8'h87); wr_idx(8'h12); wr_idx(8'h87); wr_idx(8'hF6);
      chk("R2 broken key", rdata, 8'hFF);

      // R3 unlocked but no page: reads 0, writes ignored
      wr_idx(8'h87); wr_idx(8'h87);
      rd(8'hF6, v);
      chk("R3 no page read", v, 8'h00);
      wr_dat(8'h44);
      wreg(8'h07, 8'h08);
      rd(8'h30, v); chk("R1 0x30 default", v, 8'h00);
      rd(8'hF5, v); chk("R1 0xF5 default", v, 8'h08);
      rd(8'hF6, v); chk("R3 write ignored, R1 count default", v, 8'h05);
      rd(8'hF7, v); chk("R1 0xF7 default", v, 8'h00);

      // table walk
      for (int i = 0; i < 8; i++) begin
         wreg(VT[i][23:16], VT[i][15:8]);
         rd(VT[i][23:16], v);
         chk($sformatf("R%0d table row %0d", VT_REQ[i], i), v, VT[i][7:0]);
      end

      // R4 relock
      rd(8'hF6, v);
      wr_idx(8'hAA);
      chk("R4 relocked read", rdata, 8'hFF);
      wr_dat(8'h99);
      chk("R4 still FF", rdata, 8'hFF);
      open_page();
      rd(8'hF6, v);
      chk("R4 write ignored", v, 8'h3C);

      // R8 seconds countdown and expiry
      wreg(8'hF5, 8'h00); wreg(8'hF6, 8'h03); wreg(8'h30, 8'h01);
      rd(8'hF6, v);
      ticks(1); chk("R8 count 2", rdata, 8'h02);
      ticks(1); chk("R8 count 1", rdata, 8'h01);
      chk("R8 no early reset", {7'd0, rst_req}, 8'h00);
      ticks(1); chk("R8 count 0", rdata, 8'h00);
      chk("R8 reset raised", {7'd0, rst_req}, 8'h01);
      ticks(2); chk("R8 reset held", {7'd0, rst_req}, 8'h01);
      wreg(8'h30, 8'h00);
      @(negedge clk);
      chk("R12 disable drops reset", {7'd0, rst_req}, 8'h00);

      // R12 disabled hold
      wreg(8'hF6, 8'h04);
      rd(8'hF6, v);
      ticks(3);
      chk("R12 count held", rdata, 8'h04);

      // R6 minutes prescale
      wreg(8'hF5, 8'h08); wreg(8'hF6, 8'h02); wreg(8'h30, 8'h01);
      rd(8'hF6, v);
      ticks(TPM - 1); chk("R6 no step yet", rdata, 8'h02);
      ticks(1);       chk("R6 one minute step", rdata, 8'h01);

      // R9 zero load
      wreg(8'hF6, 8'h00);
      rd(8'hF6, v);
      ticks(10);
      chk("R9 count stays 0", rdata, 8'h00);
      chk("R9 no reset", {7'd0, rst_req}, 8'h00);

      // R10 activity reload
      wreg(8'hF5, 8'h00); wreg(8'hF7, 8'h00); wreg(8'hF6, 8'h05);
      rd(8'hF6, v);
      ticks(2); chk("R7 live count", rdata, 8'h03);
      kbd_pulse(); chk("R10 kbd masked", rdata, 8'h03);
      wreg(8'hF7, 8'h40);
      rd(8'hF6, v);
      kbd_pulse(); chk("R10 kbd reload", rdata, 8'h05);
      ticks(1);
      ms_pulse(); chk("R10 mouse masked", rdata, 8'h04);
      wreg(8'hF7, 8'h80);
      rd(8'hF6, v);
      ms_pulse(); chk("R10 mouse reload", rdata, 8'h05);

      done = 1'b1;
      summary();
   end
endmodule